// File: doc/BRIEF.md
# Cascadable Sequential Configuration Store Reader

This block is the read side of a one-time-programmable configuration store. After a reset it walks its array from address zero and puts the contents on an 8-bit three-state data bus. It sends one item per clock, either one bit on the lowest data line or one whole byte on all eight lines. A chip-enable input, a combined output-enable/reset input and a stall input decide when the walk advances. A chip-enable output hands control to the next store in a chain once this store has given out its last item.

Two build-time options shape the block. `BYTE_WIDE` picks serial or byte-wide output. `RST_LOW` picks the polarity of the combined reset pin. A small synchronous load port fills the array, and it is accepted only while reset is asserted. The address counter stops one step past the last address and stays there until a reset or a standby clears it.

Top module: `cfg_stream_reader`

## Requirements
- R1: At a rising clock edge the address advances by one only when `ce_n` is low, reset is inactive, the address is not past the last index and `busy` is low.
- R2: `dq` is driven only while `ce_n` is low, reset is inactive and the address is not past the last index. Otherwise every line of `dq` is released (high impedance).
- R3: With `BYTE_WIDE`=0 the last index is 8*`DEPTH_BYTES`-1. Bit address a is bit 7-(a mod 8) of byte a/8, so each byte goes out most significant bit first on `dq[0]`, and `dq[7:1]` stay released.
- R4: With `BYTE_WIDE`=1 the last index is `DEPTH_BYTES`-1, and byte a appears on `dq[7:0]` with bit 7 on `dq[7]`.
- R5: A high `busy` at a rising edge leaves both the address and the output data unchanged.
- R6: With `RST_LOW`=0 reset is active when `oe_rst` is 1. With `RST_LOW`=1 it is active when `oe_rst` is 0. While reset is active the address is cleared to zero at each edge and `dq` is released.
- R7: While `ce_n` is high the block is in standby: `dq` is released whatever `oe_rst` is, and the address is cleared to zero at each edge.
- R8: The advancing edge that leaves the last index moves the address past it. From then on the address stays there, `dq` is released and `ceo_n` is low.
- R9: `ceo_n` is low only while `ce_n` is low, reset is inactive and the address is past the last index. It goes back high in the same cycle that reset becomes active or `ce_n` goes high.
- R10: A byte on the load port is written into the array at `ld_addr` on a rising edge only when `ld_en` is high and reset is active. A load while reset is inactive has no effect.
- R11: The data for a new address is on `dq` just after the rising edge that moves the counter to it. The first item is present as soon as reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock; all state changes on its rising edge |
| ce_n | input | 1 | Chip enable, active low; high selects standby |
| oe_rst | input | 1 | Combined output enable / reset, polarity set by `RST_LOW` |
| busy | input | 1 | Stall: high freezes the address and the output data |
| ld_en | input | 1 | Load strobe for the array, honoured only in reset |
| ld_addr | input | $clog2(DEPTH_BYTES) | Byte address for the load port |
| ld_byte | input | 8 | Byte value for the load port |
| dq | output | 8 | Three-state data bus; only bit 0 used in serial mode |
| ceo_n | output | 1 | Chip-enable output to the next store in a chain, active low |

## Verification
The bench runs a serial store with a reset that is active high next to a byte-wide store with a reset that is active low, so both polarities and both lane widths face the same stimulus. The hard cases are the hand-off at the last index and the stall. A counter that wrapped or did not saturate would start the stream again and never pull `ceo_n` low. A stall that still advanced would skip items. A wrong bit order within a byte would show as swapped serial bits. A load port that ignored the reset gate would corrupt the data the bench reads back after a second reset. Standby and a reset in the middle of a stream are checked to release the bus and raise `ceo_n` in the same cycle.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;

   // highest item index: bits in serial mode, bytes in byte-wide mode
   function automatic int unsigned last_index(input int unsigned depth_bytes,
                                              input bit byte_wide);
      return byte_wide ? (depth_bytes - 1) : (depth_bytes * 8 - 1);
   endfunction

   // counter must also hold the single "past the end" value
   function automatic int unsigned cnt_bits(input int unsigned last);
      return $clog2(last + 2);
   endfunction

endpackage

// File: rtl/cfgrd_ctrl.sv
module cfgrd_ctrl #(
   parameter int unsigned LAST    = 127,
   parameter int unsigned CW      = 8,
   parameter bit          RST_LOW = 1'b0
) (
   input  logic          clk,
   input  logic          ce_n,
   input  logic          oe_rst,
   input  logic          busy,
   output logic          rst_act,
   output logic          clr,
   output logic [CW-1:0] cnt_next,
   output logic          drive,
   output logic          ceo_n
);

   localparam logic [CW-1:0] LAST_V = CW'(LAST);

   logic [CW-1:0] cnt;
   logic          past;
   logic          adv;

   generate
      if (RST_LOW) begin : g_rst_low
         assign rst_act = ~oe_rst;
      end else begin : g_rst_high
         assign rst_act = oe_rst;
      end
   endgenerate

   assign clr  = rst_act | ce_n;
   assign past = (cnt > LAST_V);
   assign adv  = ~clr & ~past & ~busy;

   always_comb begin
      if (clr)
         cnt_next = '0;
      else if (adv)
         cnt_next = cnt + 1'b1;
      else
         cnt_next = cnt;
   end

   always_ff @(posedge clk) begin
      cnt <= cnt_next;
   end

   assign drive = ~clr & ~past;
   assign ceo_n = ~(~clr & past);

   // R1: a qualified edge moves the address by exactly one
   a_r1_advance : assert property (@(posedge clk) disable iff (clr)
      (!past && !busy) |=> (cnt == $past(cnt) + 1'b1));

   // R5: a stall freezes the address
   a_r5_busy_hold : assert property (@(posedge clk) disable iff (clr)
      busy |=> $stable(cnt));

   // R8: once past the last index the counter stays there
   a_r8_saturate : assert property (@(posedge clk) disable iff (clr)
      past |=> past);

   // R6 / R7: reset or standby clears the address
   a_r6_clear : assert property (@(posedge clk)
      clr |=> (cnt == '0));

   // R9: hand-off and data drive never overlap
   a_r9_handoff : assert property (@(posedge clk) disable iff (clr)
      !ceo_n |-> !drive);

endmodule

// File: rtl/cfgrd_store.sv
module cfgrd_store #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = 4
) (
   input  logic          clk,
   input  logic          ld_ok,
   input  logic          ld_en,
   input  logic [AW-1:0] ld_addr,
   input  logic [7:0]    ld_byte,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_byte
);

   localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

   logic [7:0] mem [DEPTH];
   logic       wr_fire;

   assign wr_fire = ld_en & ld_ok & ({1'b0, ld_addr} < DEPTH_V);

   always_ff @(posedge clk) begin
      if (wr_fire)
         mem[ld_addr] <= ld_byte;
   end

   always_comb begin
      if ({1'b0, rd_addr} < DEPTH_V)
         rd_byte = mem[rd_addr];
      else
         rd_byte = '0;
   end

endmodule

// File: rtl/cfgrd_lane.sv
module cfgrd_lane #(
   parameter bit          BYTE_WIDE = 1'b0,
   parameter int unsigned CW        = 8,
   parameter int unsigned AW        = 4
) (
   input  logic          clk,
   input  logic [CW-1:0] cnt_next,
   output logic [AW-1:0] rd_addr,
   input  logic [7:0]    rd_byte,
   input  logic          drive,
   output logic [7:0]    dq
);

   generate
      if (BYTE_WIDE) begin : g_byte
         logic [7:0] byte_q;

         assign rd_addr = AW'(cnt_next);

         always_ff @(posedge clk) begin
            byte_q <= rd_byte;
         end

         assign dq = drive ? byte_q : 8'bzzzz_zzzz;
      end else begin : g_serial
         logic       bit_q;
         logic [2:0] sel;

         assign rd_addr = AW'(cnt_next >> 3);
         assign sel     = cnt_next[2:0];

         always_ff @(posedge clk) begin
            bit_q <= rd_byte[3'd7 - sel];
         end

         assign dq[0]   = drive ? bit_q : 1'bz;
         assign dq[7:1] = 7'bzzz_zzzz;
      end
   endgenerate

endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader #(
   parameter int unsigned DEPTH_BYTES = 16,
   parameter bit          BYTE_WIDE   = 1'b0,
   parameter bit          RST_LOW     = 1'b0,
   parameter int unsigned LD_AW       = $clog2(DEPTH_BYTES)
) (
   input  logic             clk,
   input  logic             ce_n,
   input  logic             oe_rst,
   input  logic             busy,
   input  logic             ld_en,
   input  logic [LD_AW-1:0] ld_addr,
   input  logic [7:0]       ld_byte,
   output logic [7:0]       dq,
   output logic             ceo_n
);

   localparam int unsigned LAST = cfgrd_pkg::last_index(DEPTH_BYTES, BYTE_WIDE);
   localparam int unsigned CW   = cfgrd_pkg::cnt_bits(LAST);

   generate
      if (DEPTH_BYTES < 2) begin : g_bad_depth
         $error("cfg_stream_reader: DEPTH_BYTES must be at least 2");
      end
      if (LD_AW != $clog2(DEPTH_BYTES)) begin : g_bad_aw
         $error("cfg_stream_reader: LD_AW must equal clog2(DEPTH_BYTES)");
      end
   endgenerate

   logic          rst_act;
   logic          clr;
   logic [CW-1:0] cnt_next;
   logic          drive;
   logic [LD_AW-1:0] rd_addr;
   logic [7:0]    rd_byte;

   cfgrd_ctrl #(
      .LAST    (LAST),
      .CW      (CW),
      .RST_LOW (RST_LOW)
   ) i_ctrl (
      .clk      (clk),
      .ce_n     (ce_n),
      .oe_rst   (oe_rst),
      .busy     (busy),
      .rst_act  (rst_act),
      .clr      (clr),
      .cnt_next (cnt_next),
      .drive    (drive),
      .ceo_n    (ceo_n)
   );

   cfgrd_store #(
      .DEPTH (DEPTH_BYTES),
      .AW    (LD_AW)
   ) i_store (
      .clk     (clk),
      .ld_ok   (rst_act),
      .ld_en   (ld_en),
      .ld_addr (ld_addr),
      .ld_byte (ld_byte),
      .rd_addr (rd_addr),
      .rd_byte (rd_byte)
   );

   cfgrd_lane #(
      .BYTE_WIDE (BYTE_WIDE),
      .CW        (CW),
      .AW        (LD_AW)
   ) i_lane (
      .clk      (clk),
      .cnt_next (cnt_next),
      .rd_addr  (rd_addr),
      .rd_byte  (rd_byte),
      .drive    (drive),
      .dq       (dq)
   );

   // R7: standby or reset always ends in a raised hand-off line
   a_r7_idle_ceo_high : assert property (@(posedge clk)
      clr |-> ceo_n);

endmodule

// File: tb/test_cfg_stream_reader.sv
module test_cfg_stream_reader;

   localparam int S_DEPTH = 4;
   localparam int P_DEPTH = 6;
   localparam int S_LAST  = S_DEPTH * 8 - 1;
   localparam int P_LAST  = P_DEPTH - 1;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_req = 1'b1;
   logic       ce_n    = 1'b0;
   logic       busy    = 1'b0;
   logic       ld_en   = 1'b0;
   logic [2:0] ld_addr = '0;
   logic [7:0] ld_s    = '0;
   logic [7:0] ld_p    = '0;
   logic       ld_en_s;
   wire  [7:0] dq_s;
   wire  [7:0] dq_p;
   wire        ceo_s;
   wire        ceo_p;

   for (genvar g = 0; g < 8; g++) begin : g_pull
      pullup (dq_s[g]);
      pullup (dq_p[g]);
   end

   assign ld_en_s = ld_en & (ld_addr < 3'(S_DEPTH));

   cfg_stream_reader #(.DEPTH_BYTES(S_DEPTH), .BYTE_WIDE(1'b0), .RST_LOW(1'b0))
   i_cfg_stream_reader (
      .clk(clk), .ce_n(ce_n), .oe_rst(rst_req), .busy(busy),
      .ld_en(ld_en_s), .ld_addr(ld_addr[1:0]), .ld_byte(ld_s),
      .dq(dq_s), .ceo_n(ceo_s)
   );

   cfg_stream_reader #(.DEPTH_BYTES(P_DEPTH), .BYTE_WIDE(1'b1), .RST_LOW(1'b1))
   i_cfg_stream_reader_par (
      .clk(clk), .ce_n(ce_n), .oe_rst(~rst_req), .busy(busy),
      .ld_en(ld_en), .ld_addr(ld_addr), .ld_byte(ld_p),
      .dq(dq_p), .ceo_n(ceo_p)
   );

   // reference model
   logic [7:0] mem_s [S_DEPTH];
   logic [7:0] mem_p [P_DEPTH];
   int cs = 0;
   int cp = 0;
   int n_chk = 0;
   int n_fail = 0;
   string phase = "R6 reset";
   bit done = 1'b0;

   task automatic check(input string what, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s got %b exp %b", phase, what, got, exp);
      end
   endtask

   always @(posedge clk) begin
      logic       clr;
      logic       drv;
      logic [7:0] es;
      logic [7:0] ep;
      clr = rst_req | ce_n;
      if (rst_req && ld_en) begin
         if (ld_addr < 3'(S_DEPTH)) mem_s[ld_addr] = ld_s;
         if (ld_addr < 3'(P_DEPTH)) mem_p[ld_addr] = ld_p;
      end
      if (clr) begin
         cs = 0;
         cp = 0;
      end else if (!busy) begin
         if (cs <= S_LAST) cs++;
         if (cp <= P_LAST) cp++;
      end
      #2;
      drv = !clr && cs <= S_LAST;
      es  = drv ? {7'h7F, mem_s[cs / 8][7 - (cs % 8)]} : 8'hFF;
      check("serial dq", dq_s, es);
      check("serial ceo_n", {7'd0, ceo_s}, {7'd0, !(!clr && cs > S_LAST)});
      drv = !clr && cp <= P_LAST;
      ep  = drv ? mem_p[cp] : 8'hFF;
      check("byte dq", dq_p, ep);
      check("byte ceo_n", {7'd0, ceo_p}, {7'd0, !(!clr && cp > P_LAST)});
   end

   function automatic logic [7:0] fs(input int i);
      return 8'h3C ^ 8'(i * 29);
   endfunction
   function automatic logic [7:0] fp(input int i);
      return 8'hC5 + 8'(i * 51);
   endfunction

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      cycles(2);
      phase = "R10 load in reset";
      for (int i = 0; i < P_DEPTH; i++) begin
         ld_en = 1'b1; ld_addr = 3'(i); ld_s = fs(i); ld_p = fp(i);
         cycles(1);
      end
      ld_en = 1'b0;
      cycles(2);
      phase = "R1 R3 R4 R11 stream";
      rst_req = 1'b0;
      cycles(30);
      phase = "R8 hand-off";
      cycles(8);
      phase = "R9 ceo on reset";
      rst_req = 1'b1;
      cycles(1);
      phase = "R6 cleared";
      cycles(1);
      rst_req = 1'b0;
      phase = "R5 busy stall";
      for (int i = 0; i < 24; i++) begin
         busy = (i % 3 != 2);
         cycles(1);
      end
      busy = 1'b0;
      phase = "R7 standby";
      ce_n = 1'b1;
      cycles(3);
      ce_n = 1'b0;
      phase = "R2 stream";
      cycles(10);
      phase = "R10 load ignored";
      for (int i = 0; i < P_DEPTH; i++) begin
         ld_en = 1'b1; ld_addr = 3'(i); ld_s = ~fs(i); ld_p = ~fp(i);
         cycles(1);
      end
      ld_en = 1'b0;
      rst_req = 1'b1;
      cycles(2);
      rst_req = 1'b0;
      phase = "R10 reread";
      cycles(40);
      phase = "R9 ceo on ce";
      ce_n = 1'b1;
      cycles(1);
      ce_n = 1'b0;
      cycles(3);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired in phase %s", phase);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule